// File: doc/BRIEF.md
# Line Fetch Unit with Next-Line Predictor

This unit brings instruction lines from a memory command port into the front end, one line at a time, with never more than one read in flight. Each line that comes back is passed on as a bundle. A bundle holds the line address, the generation it was fetched under, the line data, and a guess at which line comes next. The guess comes from a small direct-mapped table. When the table misses, the guess is the next sequential line. The guessed successor then becomes the address of the next read, so the unit follows taken branches without waiting for decode.

The rest of the pipeline steers the unit with restart messages. A restart carries a new generation, the line that was being decoded when the redirect happened, and the line execution must continue from. A restart resets the fetch address and drops any read still in flight. It also trains the table. A jump to an unrelated line is remembered as a link from the previous line to the new one. A restart that only moves to the same line or the one after it removes the link that was stored for the previous line.

Top module: `line_fetch_unit`

## Requirements
- R1: After reset, no bundle is presented, `cmdValid` is high with `cmdLine` = 0, every table entry is empty, and the generation is 0.
- R2: `cmdValid` is high only while no read is outstanding and `restartValid` is low. A read counts as issued in the cycle where `cmdValid` and `cmdReady` are both high. From that cycle on it is outstanding until it is accepted or a restart clears it.
- R3: A response is accepted when a read is outstanding, `rspLine` equals the expected line and no restart is present. In the next cycle `bundleValid` is high for exactly one cycle, with `bundleLine` set to that line, `bundleData` set to the response data and `bundleGen` set to the current generation. Acceptance clears the outstanding read.
- R4: The successor carried in `bundleNextLine` is the stored target when the table holds an entry for the line. Otherwise it is the line plus one. The successor becomes the address of the following read.
- R5: A response that arrives while no read is outstanding, or that carries a line other than the expected one, produces no bundle. It leaves the outstanding state and the fetch address unchanged.
- R6: A restart loads `restartGen` as the generation and `restartNewLine` as the fetch address, and clears the outstanding read. The next read, one cycle later or later, is for the new line, and later bundles carry the new generation.
- R7: A restart whose new line is neither the previous line nor the previous line plus one writes an entry for the previous line pointing to the new line. The entry lives at index `prevLine[3:0]` and replaces whatever was stored there.
- R8: A restart whose new line equals the previous line, or the previous line plus one, clears the entry at `prevLine[3:0]` only if that entry was written for the previous line. An entry at that index that belongs to a different line is left intact.
- R9: When a restart and an acceptable response arrive in the same cycle, the restart is applied and the response is dropped, so no bundle follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restartValid | input | 1 | Restart message present this cycle |
| restartGen | input | GEN_W | Generation to adopt |
| restartPrevLine | input | LINE_W | Line being decoded when the redirect occurred |
| restartNewLine | input | LINE_W | Line to fetch next |
| cmdReady | input | 1 | Memory accepts a read command |
| cmdValid | output | 1 | Read command request |
| cmdLine | output | LINE_W | Line address to read |
| rspValid | input | 1 | Read response present |
| rspLine | input | LINE_W | Line address of the response |
| rspData | input | DATA_W | Line contents |
| bundleValid | output | 1 | Bundle present (one-cycle pulse) |
| bundleLine | output | LINE_W | Line address of the bundle |
| bundleNextLine | output | LINE_W | Predicted successor line |
| bundleGen | output | GEN_W | Generation the bundle belongs to |
| bundleData | output | DATA_W | Line contents |

## Verification
The assertions assume a few things about the inputs. `rspValid` is treated as a one-cycle strobe with no backpressure. Restarts may come in any cycle, including the cycle of a response. The memory does not have to return lines in request order. The stimulus keeps to this with a one-slot memory that answers after zero to three idle cycles and overwrites its slot when a new read arrives. The bench also injects stray responses while a read is outstanding and while none is, times a restart to land on a response cycle, and builds aliasing cases in which two lines share one table index.

// File: rtl/lf_pkg.sv
package lf_pkg;
  // Strobes from control to datapath: at most one of restart/accept per cycle.
  typedef struct packed {
    logic doRestart;
    logic doAccept;
    logic doIssue;
  } lfStrobe_t;
endpackage

// File: rtl/lf_predictor.sv
module lf_predictor #(
  parameter int LINE_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lookupLine,
  output logic [LINE_W-1:0] succLine,
  input  logic              trainEn,
  input  logic [LINE_W-1:0] trainPrev,
  input  logic [LINE_W-1:0] trainNew
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = LINE_W - IDX_W;

  logic              validQ  [ENTRIES];
  logic [TAG_W-1:0]  tagQ    [ENTRIES];
  logic [LINE_W-1:0] targetQ [ENTRIES];

  logic [IDX_W-1:0] lookIdx, trainIdx;
  logic [TAG_W-1:0] lookTag, trainTag;
  logic             lookHit, trainSeq, trainOwn;

  assign lookIdx  = lookupLine[IDX_W-1:0];
  assign lookTag  = lookupLine[LINE_W-1:IDX_W];
  assign lookHit  = validQ[lookIdx] && (tagQ[lookIdx] == lookTag);
  assign succLine = lookHit ? targetQ[lookIdx] : lookupLine + LINE_W'(1);

  assign trainIdx = trainPrev[IDX_W-1:0];
  assign trainTag = trainPrev[LINE_W-1:IDX_W];
  assign trainSeq = (trainNew == trainPrev) || (trainNew == trainPrev + LINE_W'(1));
  assign trainOwn = validQ[trainIdx] && (tagQ[trainIdx] == trainTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) validQ[i] <= 1'b0;
    end else if (trainEn) begin
      if (!trainSeq)     validQ[trainIdx] <= 1'b1;
      else if (trainOwn) validQ[trainIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (trainEn && !trainSeq) begin
      tagQ[trainIdx]    <= trainTag;
      targetQ[trainIdx] <= trainNew;
    end
  end

  // R7: a non-sequential redirect leaves a valid entry at its index
  a_r7_store_link: assert property (@(posedge clk) disable iff (!rstN)
    (trainEn && !trainSeq) |=> validQ[$past(trainIdx)]);

  // R8: a sequential redirect leaves no entry owned by the previous line
  a_r8_erase_link: assert property (@(posedge clk) disable iff (!rstN)
    (trainEn && trainSeq) |=>
      !(validQ[$past(trainIdx)] && tagQ[$past(trainIdx)] == $past(trainTag)));
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      restartValid,
  input  logic      rspValid,
  input  logic      lineMatch,
  input  logic      cmdReady,
  output logic      cmdValid,
  output lfStrobe_t strb
);
  logic pendingQ;

  assign cmdValid       = !pendingQ && !restartValid;
  assign strb.doRestart = restartValid;
  assign strb.doAccept  = rspValid && pendingQ && lineMatch && !restartValid;
  assign strb.doIssue   = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN)                             pendingQ <= 1'b0;
    else if (strb.doRestart || strb.doAccept) pendingQ <= 1'b0;
    else if (strb.doIssue)                 pendingQ <= 1'b1;
  end

  // R2: an issued read blocks a second command in the following cycle
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdValid);

  // R9: restart and acceptance never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |-> !strb.doAccept);
endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int LINE_W = 32,
  parameter int DATA_W = 128,
  parameter int GEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfStrobe_t         strb,
  input  logic [GEN_W-1:0]  restartGen,
  input  logic [LINE_W-1:0] restartNewLine,
  input  logic [LINE_W-1:0] rspLine,
  input  logic [DATA_W-1:0] rspData,
  input  logic [LINE_W-1:0] succLine,
  output logic              lineMatch,
  output logic [LINE_W-1:0] nextLine,
  output logic              bundleValid,
  output logic [LINE_W-1:0] bundleLine,
  output logic [LINE_W-1:0] bundleNextLine,
  output logic [GEN_W-1:0]  bundleGen,
  output logic [DATA_W-1:0] bundleData
);
  logic [LINE_W-1:0] nextLineQ;
  logic [GEN_W-1:0]  genQ;

  assign nextLine  = nextLineQ;
  assign lineMatch = (rspLine == nextLineQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextLineQ <= '0;
      genQ      <= '0;
    end else if (strb.doRestart) begin
      nextLineQ <= restartNewLine;
      genQ      <= restartGen;
    end else if (strb.doAccept) begin
      nextLineQ <= succLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bundleValid    <= 1'b0;
      bundleLine     <= '0;
      bundleNextLine <= '0;
      bundleGen      <= '0;
      bundleData     <= '0;
    end else begin
      bundleValid <= strb.doAccept;
      if (strb.doAccept) begin
        bundleLine     <= nextLineQ;
        bundleNextLine <= succLine;
        bundleGen      <= genQ;
        bundleData     <= rspData;
      end
    end
  end

  // R9: a restart cycle is never followed by a bundle
  a_r9_restart_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRestart |=> !bundleValid);

  // R3: a bundle names the line that was expected when it was accepted
  a_r3_bundle_line: assert property (@(posedge clk) disable iff (!rstN)
    bundleValid |-> (bundleLine == $past(nextLineQ)));

  // R4: after a bundle the fetch address is the advertised successor
  a_r4_follow_succ: assert property (@(posedge clk) disable iff (!rstN)
    bundleValid |-> (nextLineQ == bundleNextLine));
endmodule

// File: rtl/line_fetch_unit.sv
module line_fetch_unit
  import lf_pkg::*;
#(
  parameter int LINE_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int GEN_W       = 4,
  parameter int TBL_ENTRIES = 16,
  localparam int DATA_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartValid,
  input  logic [GEN_W-1:0]  restartGen,
  input  logic [LINE_W-1:0] restartPrevLine,
  input  logic [LINE_W-1:0] restartNewLine,
  input  logic              cmdReady,
  output logic              cmdValid,
  output logic [LINE_W-1:0] cmdLine,
  input  logic              rspValid,
  input  logic [LINE_W-1:0] rspLine,
  input  logic [DATA_W-1:0] rspData,
  output logic              bundleValid,
  output logic [LINE_W-1:0] bundleLine,
  output logic [LINE_W-1:0] bundleNextLine,
  output logic [GEN_W-1:0]  bundleGen,
  output logic [DATA_W-1:0] bundleData
);
  lfStrobe_t         strb;
  logic              lineMatch;
  logic [LINE_W-1:0] nextLine, succLine;

  assign cmdLine = nextLine;

  lf_ctrl u_ctrl (
    .clk, .rstN, .restartValid, .rspValid, .lineMatch, .cmdReady,
    .cmdValid, .strb
  );

  lf_datapath #(.LINE_W(LINE_W), .DATA_W(DATA_W), .GEN_W(GEN_W)) u_dp (
    .clk, .rstN, .strb, .restartGen, .restartNewLine, .rspLine, .rspData,
    .succLine, .lineMatch, .nextLine, .bundleValid, .bundleLine,
    .bundleNextLine, .bundleGen, .bundleData
  );

  lf_predictor #(.LINE_W(LINE_W), .ENTRIES(TBL_ENTRIES)) u_pred (
    .clk, .rstN, .lookupLine(nextLine), .succLine,
    .trainEn(restartValid), .trainPrev(restartPrevLine), .trainNew(restartNewLine)
  );
endmodule

// File: tb/tb_line_fetch_unit.sv
module tb_line_fetch_unit;
  localparam int LW = 32, DW = 128, GW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic restartValid = 1'b0, cmdReady = 1'b0, rspValid = 1'b0;
  logic [GW-1:0] restartGen = '0;
  logic [LW-1:0] restartPrevLine = '0, restartNewLine = '0, rspLine = '0;
  logic [DW-1:0] rspData = '0;
  logic cmdValid, bundleValid;
  logic [LW-1:0] cmdLine, bundleLine, bundleNextLine;
  logic [GW-1:0] bundleGen;
  logic [DW-1:0] bundleData;

  always #10 clk = ~clk;

  line_fetch_unit dut (.*);

  int nChecks = 0, nFail = 0;

  // behavioural reference state
  bit mPend, mBV;
  bit [LW-1:0] mNext, mBL, mBN;
  bit [GW-1:0] mGen, mBG;
  bit [DW-1:0] mBD;
  bit mVal[16];
  bit [LW-1:0] mOwner[16], mTgt[16];

  // environment
  bit memPend; bit [LW-1:0] memLine; int memWait;
  bit rqV; bit [GW-1:0] rqGen; bit [LW-1:0] rqPrev, rqNew;
  bit injV; bit [LW-1:0] injLine;
  bit rdyRand = 0;
  bit obsSeen; bit [LW-1:0] obsLine, obsNext; bit [GW-1:0] obsGen;

  function automatic bit [DW-1:0] lineData(bit [LW-1:0] l);
    return {l ^ 32'hA5A5_0F0F, ~l, l * 32'd2654435761, l + 32'd7};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit memUsed = 0, expCmd, issue;
    bit [LW-1:0] succ;
    restartValid = rqV; restartGen = rqGen;
    restartPrevLine = rqPrev; restartNewLine = rqNew;
    cmdReady = rdyRand ? 1'($urandom_range(0, 1)) : 1'b1;
    if (injV) begin
      rspValid = 1; rspLine = injLine; rspData = lineData(injLine);
    end else if (memPend && memWait == 0) begin
      rspValid = 1; rspLine = memLine; rspData = lineData(memLine); memUsed = 1;
    end else rspValid = 0;
    #1;
    expCmd = !mPend && !rqV;
    chk("R2 cmdValid", cmdValid, expCmd);
    if (expCmd) chk("R6 cmdLine", cmdLine, mNext);
    chk("R3/R5 bundleValid", bundleValid, mBV);
    if (mBV && bundleValid) begin
      chk("R3 bundleLine", bundleLine, mBL);
      chk("R4 bundleNextLine", bundleNextLine, mBN);
      chk("R6 bundleGen", bundleGen, mBG);
      chk("R3 bundleData", bundleData, mBD);
      obsSeen = 1; obsLine = bundleLine; obsNext = bundleNextLine; obsGen = bundleGen;
    end
    // reference update
    issue = expCmd && cmdReady;
    mBV = 0;
    if (rqV) begin
      int ix = int'(rqPrev % 16);
      mGen = rqGen; mNext = rqNew; mPend = 0;
      if (rqNew == rqPrev || rqNew == rqPrev + 1) begin
        if (mVal[ix] && mOwner[ix] == rqPrev) mVal[ix] = 0;
      end else begin
        mVal[ix] = 1; mOwner[ix] = rqPrev; mTgt[ix] = rqNew;
      end
    end else if (rspValid && mPend && rspLine == mNext) begin
      int ix = int'(mNext % 16);
      succ = (mVal[ix] && mOwner[ix] == mNext) ? mTgt[ix] : mNext + 1;
      mBV = 1; mBL = mNext; mBN = succ; mBG = mGen; mBD = rspData;
      mNext = succ; mPend = 0;
    end else if (issue) mPend = 1;
    // memory slot
    if (memUsed) memPend = 0;
    if (cmdValid && cmdReady) begin
      memPend = 1; memLine = cmdLine; memWait = $urandom_range(0, 3);
    end else if (memPend && memWait > 0) memWait--;
    rqV = 0; injV = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart(int g, int prev, int nw);
    rqV = 1; rqGen = GW'(g); rqPrev = LW'(prev); rqNew = LW'(nw);
    step();
  endtask

  task automatic runTo(int l);
    obsSeen = 0;
    for (int i = 0; i < 300; i++) begin
      if (obsSeen && obsLine == LW'(l)) break;
      step();
    end
  endtask

  initial begin
    #3_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 cmdValid", cmdValid, 1);
    chk("R1 cmdLine", cmdLine, 0);
    chk("R1 bundleValid", bundleValid, 0);
    // R4: sequential default successor on an empty table
    runTo(2);
    chk("R4 miss successor", obsNext, 3);
    chk("R1 initial generation", obsGen, 0);
    // R7: non-sequential redirect trains 2 -> 0x40
    restart(1, 2, 'h40);
    runTo('h40);
    chk("R6 generation after restart", obsGen, 1);
    restart(2, 'h41, 2);
    runTo(2);
    chk("R7 trained successor", obsNext, 'h40);
    // R8: sequential redirect erases entry for line 2
    restart(3, 2, 3);
    restart(4, 9, 2);
    runTo(2);
    chk("R8 erased entry", obsNext, 3);
    // R8: alias at index 5 must survive erase from line 0x15
    restart(5, 5, 'h80);
    restart(6, 'h15, 'h16);
    restart(7, 'h30, 5);
    runTo(5);
    chk("R8 alias kept", obsNext, 'h80);
    // R9: restart lands on a response cycle
    for (int i = 0; i < 50; i++) begin
      if (memPend && memWait == 0 && mPend && memLine == mNext) break;
      step();
    end
    restart(8, 'h33, 'h200);
    chk("R9 no bundle after restart", bundleValid, 0);
    // R5: matching response while idle
    rdyRand = 0;
    restart(9, 'h201, 'h300);
    injV = 1; injLine = 'h300; cmdReady = 0;
    step();
    chk("R5 idle response ignored", bundleValid, 0);
    // R5: mismatching response while outstanding
    for (int i = 0; i < 10 && !mPend; i++) step();
    injV = 1; injLine = mNext ^ 'h100;
    step();
    chk("R5 wrong line ignored", bundleValid, 0);
    // random traffic
    rdyRand = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) begin
        rqV = 1; rqGen = GW'($urandom); rqPrev = LW'($urandom_range(0, 63));
        rqNew = ($urandom_range(0, 1) == 1) ? rqPrev + LW'($urandom_range(0, 1))
                                            : LW'($urandom_range(0, 63));
      end
      if ($urandom_range(0, 99) < 4) begin
        injV = 1; injLine = ($urandom_range(0, 1) == 1) ? mNext : LW'($urandom_range(0, 63));
      end
      step();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule